// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block holds five down-counting timer channels behind a small word-addressed register interface. Channels 0 to 3 each drive a PWM pin. Channel 4 is an internal interval timer with no compare value and no pin. Each channel counts down at a tick rate set by a shared 8-bit prescaler and a per-channel power-of-two divider. When the counter passes through zero, the channel emits a one-cycle underflow pulse. With reload enabled, the channel then reloads and runs again; otherwise it parks at zero.

Count and compare values are double buffered. Software writes the buffers at any time. The live counter and compare registers take the buffered values only in two cases: while the channel's update bit is held, or when an underflow occurs with reload enabled. A pin starts each period low and goes high when a decrement lands the counter on the compare value. The match is tested only after a decrement, so a compare value equal to the loaded count never raises the pin. An inverter bit flips the driven pin level.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, every register reads zero, all PWM pins are low and no underflow pulse is active.
- R2: Word address map: 0 = prescalers (bits 7:0 serve channels 0–1, bits 15:8 serve channels 2–4); 1 = divider selects (4 bits per channel at offset channel*4); 2 = control; 3–7 = count buffers of channels 0–4; 8–11 = compare buffers of channels 0–3; 12–16 = read-only live counts of channels 0–4. Buffers keep only the low CNT_W bits written, writes to the live-count words change nothing, and unmapped words read zero.
- R3: While a channel's update bit is set, the live count and compare are copied from the buffers every clock, counting is suspended and the pin level returns low; the copy takes effect on the clock edge after the bit is seen.
- R4: With start set and update clear, the live count falls by one on each channel tick; with start clear the count holds.
- R5: The tick period in clocks is (prescaler+1) × 2^code for divider codes 0–4 (codes above 4 act as 4), so an auto-reloading channel loaded with N underflows every (N+1) × (prescaler+1) × 2^code clocks.
- R6: A channel's pin level goes high on the tick that decrements its count to the compare value C. With load N and C < N, the level is high exactly while the count is at or below C; with C ≥ N it never rises.
- R7: At underflow with reload set, the live count and compare reload from the buffers and the level returns low; a buffer written mid-period changes nothing until then.
- R8: At underflow with reload clear, the channel stops at zero after exactly one underflow pulse, until the next update.
- R9: Each underflow raises that channel's underflow bit for exactly one clock, in the cycle after the tick that found the count at zero.
- R10: The inverter bit inverts the driven pin of channels 0–3 immediately, without affecting counting.
- R11: Control bits for channel n ≤ 3 sit at base b = 0 for n = 0 and b = (n+1)*4 otherwise, with b = start, b+1 = update, b+2 = invert, b+3 = reload. Channel 4 uses bit 20 = start, bit 21 = update and bit 22 = reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | PWM pins of channels 0–3 |
| underflow | output | 5 | One-cycle underflow pulse per channel |

## Verification
The bench builds the timer with an 8-bit counter and 8-bit prescalers. The narrow counter makes truncation of a nine-bit buffer write observable, and it keeps full periods short enough to follow every count value tick by tick. With prescaler 0 and divider code 0, a channel ticks every clock, so each count, pin level and underflow cycle can be predicted exactly. Nonzero prescalers combined with divider codes 1, 2 and 4 bring the divided rates within reach. These are measured as the spacing of steady-state underflow pulses on channels from both prescaler groups, including the internal channel.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int NUM_CH     = 5;
    localparam int NUM_PIN    = 4;
    localparam int NUM_GRP    = 2;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 5;
    localparam int DIVSEL_W   = 4;
    localparam int DIV_MAXLOG = 4;

    // word addresses
    localparam int A_PRESCALE = 0;
    localparam int A_DIVSEL   = 1;
    localparam int A_CTRL     = 2;
    localparam int A_CNTBUF   = 3;
    localparam int A_CMPBUF   = A_CNTBUF + NUM_CH;
    localparam int A_LIVE     = A_CMPBUF + NUM_PIN;

    // the last channel uses fixed control bits
    localparam int LAST_START  = 20;
    localparam int LAST_UPDATE = 21;
    localparam int LAST_RELOAD = 22;

    typedef struct packed {
        logic start;
        logic update;
        logic invert;
        logic reload;
    } chan_ctl_t;

    function automatic int ctl_base(input int ch);
        return (ch == 0) ? 0 : (ch + 1) * 4;
    endfunction

    function automatic int pre_group(input int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

    function automatic chan_ctl_t ctl_decode(input logic [REG_W-1:0] word, input int ch);
        chan_ctl_t c;
        if (ch < NUM_PIN) begin
            c.start  = word[ctl_base(ch)];
            c.update = word[ctl_base(ch) + 1];
            c.invert = word[ctl_base(ch) + 2];
            c.reload = word[ctl_base(ch) + 3];
        end else begin
            c.start  = word[LAST_START];
            c.update = word[LAST_UPDATE];
            c.invert = 1'b0;
            c.reload = word[LAST_RELOAD];
        end
        return c;
    endfunction

    function automatic logic [DIVSEL_W-1:0] div_mask(input logic [DIVSEL_W-1:0] code);
        logic [DIVSEL_W-1:0] m;
        m = '0;
        for (int i = 0; i < DIV_MAXLOG; i++) begin
            if (code > DIVSEL_W'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [REG_W-1:0]     rd_data,
    input  logic [CNT_W-1:0]     live_cnt [NUM_CH],
    output logic [PRE_W-1:0]     pre_val  [NUM_GRP],
    output logic [DIVSEL_W-1:0]  div_sel  [NUM_CH],
    output chan_ctl_t            ctl      [NUM_CH],
    output logic [CNT_W-1:0]     cnt_buf  [NUM_CH],
    output logic [CNT_W-1:0]     cmp_buf  [NUM_CH]
);

    localparam int PS_W = NUM_GRP * PRE_W;
    localparam int DS_W = NUM_CH * DIVSEL_W;

    logic [PS_W-1:0]  prescale_q;
    logic [DS_W-1:0]  divsel_q;
    logic [REG_W-1:0] ctrl_q;
    logic [CNT_W-1:0] cnt_buf_q [NUM_CH];
    logic [CNT_W-1:0] cmp_buf_q [NUM_PIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_q <= '0;
            divsel_q   <= '0;
            ctrl_q     <= '0;
            for (int c = 0; c < NUM_CH; c++)  cnt_buf_q[c] <= '0;
            for (int c = 0; c < NUM_PIN; c++) cmp_buf_q[c] <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_PRESCALE)) prescale_q <= wr_data[PS_W-1:0];
            if (wr_addr == ADDR_W'(A_DIVSEL))   divsel_q   <= wr_data[DS_W-1:0];
            if (wr_addr == ADDR_W'(A_CTRL))     ctrl_q     <= wr_data;
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr == ADDR_W'(A_CNTBUF + c)) cnt_buf_q[c] <= wr_data[CNT_W-1:0];
            end
            for (int c = 0; c < NUM_PIN; c++) begin
                if (wr_addr == ADDR_W'(A_CMPBUF + c)) cmp_buf_q[c] <= wr_data[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_PRESCALE)) rd_data = REG_W'(prescale_q);
        if (rd_addr == ADDR_W'(A_DIVSEL))   rd_data = REG_W'(divsel_q);
        if (rd_addr == ADDR_W'(A_CTRL))     rd_data = ctrl_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(A_CNTBUF + c)) rd_data = REG_W'(cnt_buf_q[c]);
            if (rd_addr == ADDR_W'(A_LIVE + c))   rd_data = REG_W'(live_cnt[c]);
        end
        for (int c = 0; c < NUM_PIN; c++) begin
            if (rd_addr == ADDR_W'(A_CMPBUF + c)) rd_data = REG_W'(cmp_buf_q[c]);
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
        assign pre_val[g] = prescale_q[g*PRE_W +: PRE_W];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign div_sel[c] = divsel_q[c*DIVSEL_W +: DIVSEL_W];
        assign ctl[c]     = ctl_decode(ctrl_q, c);
        assign cnt_buf[c] = cnt_buf_q[c];
        if (c < NUM_PIN) begin : g_cmp
            assign cmp_buf[c] = cmp_buf_q[c];
        end else begin : g_nocmp
            assign cmp_buf[c] = '0;
        end
    end

endmodule

// File: rtl/pwmt_clkgen.sv
module pwmt_clkgen
    import pwmt_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PRE_W-1:0]    pre_val [NUM_GRP],
    input  logic [DIVSEL_W-1:0] div_sel [NUM_CH],
    output logic [NUM_CH-1:0]   tick
);

    logic [NUM_GRP-1:0] pre_tick;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [PRE_W-1:0]      pre_cnt;
        logic [DIV_MAXLOG-1:0] div_cnt;

        assign pre_tick[g] = !rst && (pre_cnt >= pre_val[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pre_cnt <= '0;
                div_cnt <= '0;
            end else if (pre_tick[g]) begin
                pre_cnt <= '0;
                div_cnt <= div_cnt + DIV_MAXLOG'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end

        // two prescaler pulses never sit back to back unless the prescaler is zero
        AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (rst)
            (pre_tick[g] && (pre_val[g] != '0) && $stable(pre_val[g])) |-> !$past(pre_tick[g])); // R5
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_div
        localparam int GRP = pre_group(c);
        logic [DIVSEL_W-1:0] mask;
        assign mask    = div_mask(div_sel[c]);
        assign tick[c] = pre_tick[GRP] &&
                         ((g_grp[GRP].div_cnt & mask[DIV_MAXLOG-1:0]) == mask[DIV_MAXLOG-1:0]);
    end

endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan
    import pwmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  chan_ctl_t        ctl,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] live_cnt,
    output logic             level,
    output logic             uf_pulse
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cmp_q, cmp_d;
    logic             lvl_q, lvl_d;
    logic             done_q, done_d;
    logic             uf_q, uf_d;
    logic [CNT_W-1:0] dec_val;
    logic             hit;

    assign dec_val = cnt_q - CNT_ONE;
    assign hit     = HAS_CMP && (dec_val == cmp_q);

    always_comb begin
        cnt_d  = cnt_q;
        cmp_d  = cmp_q;
        lvl_d  = lvl_q;
        done_d = done_q;
        uf_d   = 1'b0;
        if (ctl.update) begin
            cnt_d  = cnt_buf;
            cmp_d  = cmp_buf;
            lvl_d  = 1'b0;
            done_d = 1'b0;
        end else if (ctl.start && tick && !done_q) begin
            if (cnt_q == '0) begin
                uf_d = 1'b1;
                if (ctl.reload) begin
                    cnt_d = cnt_buf;
                    cmp_d = cmp_buf;
                    lvl_d = 1'b0;
                end else begin
                    done_d = 1'b1;
                end
            end else begin
                cnt_d = dec_val;
                if (hit) lvl_d = !lvl_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            lvl_q  <= 1'b0;
            done_q <= 1'b0;
            uf_q   <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            cmp_q  <= cmp_d;
            lvl_q  <= lvl_d;
            done_q <= done_d;
            uf_q   <= uf_d;
        end
    end

    assign live_cnt = cnt_q;
    assign level    = lvl_q;
    assign uf_pulse = uf_q;

    AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (rst)
        ctl.update |=> (cnt_q == $past(cnt_buf)) && !lvl_q); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.update && !ctl.start) |=> $stable(cnt_q)); // R4
    AST_UF_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
        uf_q |-> ($past(cnt_q) == '0) && $past(tick)); // R9
    AST_RELOAD_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (uf_q && $past(ctl.reload)) |-> (cnt_q == $past(cnt_buf)) && !lvl_q); // R7
    AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (rst)
        (uf_q && !$past(ctl.reload)) |=> (cnt_q == '0) && !uf_q); // R8

    if (HAS_CMP) begin : g_match_chk
        AST_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
            $rose(lvl_q) |-> (cnt_q == cmp_q) && ($past(cnt_q) != cmp_q)); // R6
    end

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [REG_W-1:0]   rd_data,
    output logic [NUM_PIN-1:0] pwm_out,
    output logic [NUM_CH-1:0]  underflow
);

    logic [CNT_W-1:0]    live_cnt [NUM_CH];
    logic [PRE_W-1:0]    pre_val  [NUM_GRP];
    logic [DIVSEL_W-1:0] div_sel  [NUM_CH];
    chan_ctl_t           ctl      [NUM_CH];
    logic [CNT_W-1:0]    cnt_buf  [NUM_CH];
    logic [CNT_W-1:0]    cmp_buf  [NUM_CH];
    logic [NUM_CH-1:0]   tick;
    logic [NUM_CH-1:0]   level;
    logic                spare_level_unused;

    pwmt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .live_cnt (live_cnt),
        .pre_val  (pre_val),
        .div_sel  (div_sel),
        .ctl      (ctl),
        .cnt_buf  (cnt_buf),
        .cmp_buf  (cmp_buf)
    );

    pwmt_clkgen #(.PRE_W(PRE_W)) i_clkgen (
        .clk     (clk),
        .rst     (rst),
        .pre_val (pre_val),
        .div_sel (div_sel),
        .tick    (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwmt_chan #(.CNT_W(CNT_W), .HAS_CMP(c < NUM_PIN)) i_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick[c]),
            .ctl      (ctl[c]),
            .cnt_buf  (cnt_buf[c]),
            .cmp_buf  (cmp_buf[c]),
            .live_cnt (live_cnt[c]),
            .level    (level[c]),
            .uf_pulse (underflow[c])
        );
        if (c < NUM_PIN) begin : g_pin
            assign pwm_out[c] = level[c] ^ ctl[c].invert;
        end
    end

    assign spare_level_unused = level[NUM_CH-1];

    AST_PIN_FOLLOWS_INVERT: assert property (@(posedge clk) disable iff (rst)
        ($stable(level[0]) && $changed(ctl[0].invert)) |-> $changed(pwm_out[0])); // R10

endmodule

// File: tb/test_pwm_timer_bank.sv
module test_pwm_timer_bank;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    wire  [31:0] rd_data;
    wire  [3:0]  pwm_out;
    wire  [4:0]  underflow;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pwm_timer_bank #(.CNT_W(CW), .PRE_W(8)) i_pwm_timer_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .underflow(underflow)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 5'(a);
        #1;
        d = rd_data;
    endtask

    // control layout per R11
    function automatic logic [31:0] cbits(input int ch, input bit st, input bit up, input bit inv, input bit rl);
        logic [31:0] w;
        int b;
        w = '0;
        if (ch < 4) begin
            b = (ch == 0) ? 0 : (ch + 1) * 4;
            w[b] = st; w[b+1] = up; w[b+2] = inv; w[b+3] = rl;
        end else begin
            w[20] = st; w[21] = up; w[22] = rl;
        end
        return w;
    endfunction

    task automatic load(input int ch, input int n, input int c, input bit rl);
        wr(3 + ch, n);
        if (ch < 4) wr(8 + ch, c);
        wr(2, cbits(ch, 0, 1, 0, rl));
        wr(2, cbits(ch, 1, 0, 0, rl));
    endtask

    // R1
    task automatic t_reset();
        logic [31:0] v;
        chk("R1", "pins", 32'(pwm_out), 0);
        chk("R1", "underflow", 32'(underflow), 0);
        for (int a = 0; a < 17; a++) begin
            rd(a, v);
            chk("R1", $sformatf("word %0d", a), v, 0);
        end
    endtask

    // R2
    task automatic t_regs();
        logic [31:0] v;
        wr(1, 32'h0001_2345); rd(1, v); chk("R2", "divider word", v, 32'h0001_2345);
        wr(0, 32'hFFFF_A5C3); rd(0, v); chk("R2", "prescale word", v, 32'h0000_A5C3);
        wr(11, 32'h0000_01AB); rd(11, v); chk("R2", "compare buffer 3 truncation", v, 32'hAB);
        wr(7, 32'h0000_0177); rd(7, v); chk("R2", "count buffer 4 truncation", v, 32'h77);
        wr(12, 32'h55); rd(12, v); chk("R2", "live count not writable", v, 0);
        rd(20, v); chk("R2", "unmapped word", v, 0);
        wr(0, 0); wr(1, 0); wr(7, 0); wr(11, 0);
    endtask

    // R10 R11: inverter bits one channel at a time, levels all low
    task automatic t_invert();
        for (int ch = 0; ch < 4; ch++) begin
            wr(2, cbits(ch, 0, 0, 1, 0));
            #1;
            chk("R10 R11", $sformatf("invert ch%0d", ch), 32'(pwm_out), 32'(1 << ch));
        end
        wr(2, 0);
    endtask

    // R4 R6 R7 R9: running pattern, tick every clock
    task automatic run_pattern(input int ch, input int n, input int c, input int steps, input string req);
        logic [31:0] v;
        int ec;
        bit eo, eu;
        load(ch, n, c, 1);
        for (int k = 0; k <= steps; k++) begin
            if (k > 0) @(negedge clk);
            rd(12 + ch, v);
            ec = n - (k % (n + 1));
            eo = (c < n) && (ec <= c);
            eu = (k > 0) && (k % (n + 1) == 0);
            chk(req, $sformatf("ch%0d count k=%0d", ch, k), v, 32'(ec));
            chk(req, $sformatf("ch%0d pin k=%0d", ch, k), 32'(pwm_out[ch]), 32'(eo));
            chk(req, $sformatf("ch%0d underflow k=%0d", ch, k), 32'(underflow[ch]), 32'(eu));
        end
    endtask

    // R4: clearing start freezes the count
    task automatic t_stop();
        logic [31:0] a, b;
        wr(2, cbits(0, 0, 0, 0, 1));
        rd(12, a);
        repeat (5) @(negedge clk);
        rd(12, b);
        chk("R4", "held count after stop", b, a);
    endtask

    // R3: update held with start set suspends counting and clears level
    task automatic t_update_hold();
        logic [31:0] v;
        wr(3, 9); wr(8, 9);
        wr(2, cbits(0, 1, 1, 0, 1));
        repeat (4) @(negedge clk);
        rd(12, v); chk("R3", "count pinned to buffer", v, 9);
        chk("R3", "level low during update", 32'(pwm_out[0]), 0);
        wr(2, cbits(0, 1, 0, 0, 1));
        rd(12, v); chk("R3", "count at release", v, 9);
        @(negedge clk);
        rd(12, v); chk("R3 R4", "first decrement after release", v, 8);
    endtask

    // R8 R9: one-shot
    task automatic t_oneshot();
        logic [31:0] v;
        int pulses = 0;
        load(1, 3, 9, 0);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (underflow[1]) pulses++;
        end
        rd(13, v);
        chk("R8", "parked count", v, 0);
        chk("R8 R9", "single underflow pulse", 32'(pulses), 1);
    endtask

    // R7: buffer write mid-period waits for reload
    task automatic t_buffer();
        logic [31:0] v;
        int maxc = 0;
        int gap = 0;
        bit seen = 0;
        load(2, 3, 200, 1);
        wr(5, 6);
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            rd(14, v);
            if (underflow[2]) begin
                seen = 1;
                chk("R7", "reloaded from new buffer", v, 6);
            end else if (int'(v) > maxc) maxc = int'(v);
        end
        chk("R7", "underflow reached", 32'(seen), 1);
        chk("R7", "old period kept old count", 32'(maxc <= 3), 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            gap++;
            if (underflow[2]) break;
        end
        chk("R7 R9", "new period length", 32'(gap), 7);
    endtask

    // R5 R11: divided rates on channels 0, 2 and 4
    task automatic t_rate();
        int cnt [3];
        int t   [3][3];
        int idx [3] = '{0, 2, 4};
        wr(0, 32'h0000_0201);
        wr(1, 32'h0004_0201);
        wr(3, 2); wr(5, 1); wr(7, 0);
        wr(2, cbits(0, 0, 1, 0, 1) | cbits(2, 0, 1, 0, 1) | cbits(4, 0, 1, 0, 1));
        wr(2, cbits(0, 1, 0, 0, 1) | cbits(2, 1, 0, 0, 1) | cbits(4, 1, 0, 0, 1));
        for (int j = 0; j < 3; j++) cnt[j] = 0;
        for (int cy = 0; cy < 400; cy++) begin
            @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                if (underflow[idx[j]] && cnt[j] < 3) begin
                    t[j][cnt[j]] = cy;
                    cnt[j]++;
                end
            end
        end
        for (int j = 0; j < 3; j++) chk("R5", $sformatf("ch%0d pulses seen", idx[j]), 32'(cnt[j]), 3);
        chk("R5", "ch0 interval pre1 div2", 32'(t[0][2] - t[0][1]), 12);
        chk("R5", "ch2 interval pre2 div4", 32'(t[1][2] - t[1][1]), 24);
        chk("R5 R11", "ch4 interval pre2 div16", 32'(t[2][2] - t[2][1]), 48);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_invert();
        run_pattern(0, 5, 2, 14, "R4 R6 R7 R9");
        t_stop();
        t_update_hold();
        run_pattern(1, 4, 4, 12, "R6 equal compare");
        t_oneshot();
        run_pattern(3, 3, 0, 9, "R6 R11 ch3");
        t_buffer();
        t_rate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule